// File: doc/BRIEF.md
# USB2 PHY Bring-Up and Shut-Down Sequencer

This block drives the power and reset controls of a two-port USB2 PHY. For a port that is asked to come up, it turns on the PHY reference clock and releases the shared power-on reset. It then asks an external test-register writer to set the PHY clock-enable bit, and finally releases that port's UTMI reset. After each step it waits a programmable number of settle ticks. When a port is asked to go down, it puts that port's UTMI reset back. If no other port is still up, it also re-asserts the power-on reset and gates the reference clock.

Requests arrive as single-cycle pulses and are held until the sequencer is idle. Exit requests are served before init requests, and among requests of the same kind the lower port goes first. The reference clock and power-on reset are shared by both ports. An init for a port finds them already up when the other port is running, and in that case it runs only the configuration write and its own UTMI release. The settle tick is expected to pulse once per microsecond, so the default delays are counts of microseconds.

Top module: `usbphy_bringup_seq`

## Requirements
- R1: After reset, `ref_clk_en_o`=0, `por_rst_o`=1, every bit of `utmi_rst_o`=1, every bit of `port_done_o`=0 and `cfg_wr_req_o`=0.
- R2: A full bring-up changes the outputs in this order: `ref_clk_en_o` rises, then `por_rst_o` falls, then `cfg_wr_req_o` rises, then the port's `utmi_rst_o` bit falls, then its `port_done_o` bit rises.
- R3: Exactly REF_TICKS, POR_TICKS, CFG_TICKS and UTMI_TICKS settle ticks are counted between, in turn: the reference-clock enable and the power-on-reset release; that release and the write request; the write acknowledge and the UTMI release; the UTMI release and done.
- R4: While `cfg_wr_req_o` is high it presents port 0 on `cfg_wr_port_o`, address 0x06 on `cfg_wr_addr_o` and data 0x04 (only bit 2 set) on `cfg_wr_data_o`. It stays high until `cfg_wr_ack_i` is seen, and exactly one write is issued per bring-up, whichever port is being brought up.
- R5: Bringing up port p releases only bit p of `utmi_rst_o`. Bit p of `port_done_o` corresponds to port p.
- R6: If the power-on reset is already released when an init is served, the reference clock and power-on reset do not change. Only the write, the UTMI release and done follow.
- R7: An exit of the last running port asserts its UTMI reset, then the power-on reset on the next cycle, then drops the reference clock on the cycle after that.
- R8: An exit while another port is still up asserts only that port's UTMI reset and clears its done bit. The clock and power-on reset stay on.
- R9: An init request that arrives while a sequence runs is held and served after that sequence completes.
- R10: Pending exits are served before pending inits. Among requests of the same kind, port 0 is served before port 1.
- R11: An init for a port that is already done, or an exit for a port that is not done, causes no output change.
- R12: `port_done_o[p]` is high only while `utmi_rst_o[p]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| settle_tick_i | input | 1 | One-cycle pulse per settle-time unit |
| init_req_i | input | NUM_PORTS | Per-port bring-up request pulse |
| exit_req_i | input | NUM_PORTS | Per-port shut-down request pulse |
| cfg_wr_ack_i | input | 1 | Test-register writer has accepted the write |
| ref_clk_en_o | output | 1 | PHY reference clock enable |
| por_rst_o | output | 1 | PHY power-on reset, 1 = asserted |
| utmi_rst_o | output | NUM_PORTS | Per-port UTMI reset, 1 = asserted |
| cfg_wr_req_o | output | 1 | Write request to the test-register writer |
| cfg_wr_port_o | output | 3 | Target port of the write |
| cfg_wr_addr_o | output | 8 | Target register address of the write |
| cfg_wr_data_o | output | 8 | Write data |
| port_done_o | output | NUM_PORTS | Per-port ready flag |

## Verification
The interesting collisions are two requests presented in the same cycle. In one case, an exit for the only running port arrives together with an init for the idle port. The bench checks that the full shut-down (reference clock falling) is stamped before the following full bring-up (reference clock rising), and that port 0 ends ready. In the other case, both ports are up and both exits are pulsed in one cycle. The bench checks that port 0's UTMI reset rises before port 1's, and that the shared controls go down only after the second exit.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REF_WAIT  = 3'd1,
        ST_POR_WAIT  = 3'd2,
        ST_CFG_REQ   = 3'd3,
        ST_CFG_WAIT  = 3'd4,
        ST_UTMI_WAIT = 3'd5,
        ST_DOWN_POR  = 3'd6,
        ST_DOWN_REF  = 3'd7
    } seq_state_e;

    // Configuration write that turns on the PHY clock
    localparam logic [2:0] CFG_TARGET_PORT = 3'd0;
    localparam logic [7:0] CFG_TARGET_ADDR = 8'h06;
    localparam int         CFG_CLK_EN_BIT  = 2;

endpackage

// File: rtl/usbphy_settle_timer.sv
module usbphy_settle_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_NO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1))) // R3
        else $error("settle counter moved by more than one");

endmodule

// File: rtl/usbphy_req_arb.sv
module usbphy_req_arb #(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PORTS-1:0] init_req_i,
    input  logic [NUM_PORTS-1:0] exit_req_i,
    input  logic                 take_i,
    output logic                 pick_valid_o,
    output logic                 pick_exit_o,
    output logic [PORT_W-1:0]    pick_port_o
);

    typedef struct packed {
        logic [NUM_PORTS-1:0] init_pend;
        logic [NUM_PORTS-1:0] exit_pend;
    } arb_state_t;

    arb_state_t s_d, s_q;
    logic [NUM_PORTS-1:0] clr_init, clr_exit;

    always_comb begin
        pick_valid_o = 1'b0;
        pick_exit_o  = 1'b0;
        pick_port_o  = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (s_q.init_pend[i]) begin
                pick_valid_o = 1'b1;
                pick_port_o  = PORT_W'(i);
            end
        end
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (s_q.exit_pend[i]) begin
                pick_valid_o = 1'b1;
                pick_exit_o  = 1'b1;
                pick_port_o  = PORT_W'(i);
            end
        end
    end

    always_comb begin
        clr_init = '0;
        clr_exit = '0;
        if (take_i && pick_valid_o) begin
            if (pick_exit_o) clr_exit[pick_port_o] = 1'b1;
            else             clr_init[pick_port_o] = 1'b1;
        end
        s_d.init_pend = (s_q.init_pend & ~clr_init) | init_req_i;
        s_d.exit_pend = (s_q.exit_pend & ~clr_exit) | exit_req_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    AST_EXIT_BEFORE_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.exit_pend != '0) |-> (pick_valid_o && pick_exit_o)) // R10
        else $error("init picked while an exit waits");

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_hold
        AST_INIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (s_q.init_pend[g] && !(take_i && !pick_exit_o && pick_port_o == PORT_W'(g)))
            |=> s_q.init_pend[g]) // R9
            else $error("pending init lost");
    end

endmodule

// File: rtl/usbphy_bringup_seq.sv
module usbphy_bringup_seq
    import usbphy_seq_pkg::*;
#(
    parameter int NUM_PORTS  = 2,
    parameter int REF_TICKS  = 100,
    parameter int POR_TICKS  = 300,
    parameter int CFG_TICKS  = 2000,
    parameter int UTMI_TICKS = 2000
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 settle_tick_i,
    input  logic [NUM_PORTS-1:0] init_req_i,
    input  logic [NUM_PORTS-1:0] exit_req_i,
    input  logic                 cfg_wr_ack_i,
    output logic                 ref_clk_en_o,
    output logic                 por_rst_o,
    output logic [NUM_PORTS-1:0] utmi_rst_o,
    output logic                 cfg_wr_req_o,
    output logic [2:0]           cfg_wr_port_o,
    output logic [7:0]           cfg_wr_addr_o,
    output logic [7:0]           cfg_wr_data_o,
    output logic [NUM_PORTS-1:0] port_done_o
);

    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int MAX_A  = (REF_TICKS > POR_TICKS) ? REF_TICKS : POR_TICKS;
    localparam int MAX_B  = (CFG_TICKS > UTMI_TICKS) ? CFG_TICKS : UTMI_TICKS;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    typedef struct packed {
        seq_state_e           st;
        logic                 ref_en;
        logic                 por_rst;
        logic [NUM_PORTS-1:0] utmi_rst;
        logic [NUM_PORTS-1:0] up;
        logic [PORT_W-1:0]    port;
    } seq_t;

    seq_t s_d, s_q;

    logic              take;
    logic              pick_valid, pick_exit;
    logic [PORT_W-1:0] pick_port;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic              others_up;

    usbphy_req_arb #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) u_arb (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .init_req_i   (init_req_i),
        .exit_req_i   (exit_req_i),
        .take_i       (take),
        .pick_valid_o (pick_valid),
        .pick_exit_o  (pick_exit),
        .pick_port_o  (pick_port)
    );

    usbphy_settle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (settle_tick_i),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        others_up = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (PORT_W'(i) != pick_port && s_q.up[i]) others_up = 1'b1;
        end
    end

    always_comb begin
        s_d      = s_q;
        take     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (pick_valid) begin
                    take = 1'b1;
                    if (pick_exit) begin
                        if (s_q.up[pick_port]) begin
                            s_d.utmi_rst[pick_port] = 1'b1;
                            s_d.up[pick_port]       = 1'b0;
                            if (!others_up) s_d.st = ST_DOWN_POR;
                        end
                    end else if (!s_q.up[pick_port]) begin
                        s_d.port = pick_port;
                        if (!s_q.por_rst) begin
                            s_d.st = ST_CFG_REQ;
                        end else begin
                            s_d.ref_en = 1'b1;
                            tmr_load   = 1'b1;
                            tmr_val    = CNT_W'(REF_TICKS);
                            s_d.st     = ST_REF_WAIT;
                        end
                    end
                end
            end
            ST_REF_WAIT: begin
                if (tmr_expired) begin
                    s_d.por_rst = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(POR_TICKS);
                    s_d.st      = ST_POR_WAIT;
                end
            end
            ST_POR_WAIT: begin
                if (tmr_expired) s_d.st = ST_CFG_REQ;
            end
            ST_CFG_REQ: begin
                if (cfg_wr_ack_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(CFG_TICKS);
                    s_d.st   = ST_CFG_WAIT;
                end
            end
            ST_CFG_WAIT: begin
                if (tmr_expired) begin
                    s_d.utmi_rst[s_q.port] = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(UTMI_TICKS);
                    s_d.st   = ST_UTMI_WAIT;
                end
            end
            ST_UTMI_WAIT: begin
                if (tmr_expired) begin
                    s_d.up[s_q.port] = 1'b1;
                    s_d.st           = ST_IDLE;
                end
            end
            ST_DOWN_POR: begin
                s_d.por_rst = 1'b1;
                s_d.st      = ST_DOWN_REF;
            end
            ST_DOWN_REF: begin
                s_d.ref_en = 1'b0;
                s_d.st     = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st       <= ST_IDLE;
            s_q.ref_en   <= 1'b0;
            s_q.por_rst  <= 1'b1;
            s_q.utmi_rst <= '1;
            s_q.up       <= '0;
            s_q.port     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_clk_en_o  = s_q.ref_en;
    assign por_rst_o     = s_q.por_rst;
    assign utmi_rst_o    = s_q.utmi_rst;
    assign port_done_o   = s_q.up;
    assign cfg_wr_req_o  = (s_q.st == ST_CFG_REQ);
    assign cfg_wr_port_o = CFG_TARGET_PORT;
    assign cfg_wr_addr_o = CFG_TARGET_ADDR;
    assign cfg_wr_data_o = 8'(1) << CFG_CLK_EN_BIT;

    AST_POR_NEEDS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !por_rst_o |-> ref_clk_en_o) // R2
        else $error("power-on reset released without reference clock");

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_req_o && !cfg_wr_ack_i) |=> cfg_wr_req_o) // R4
        else $error("write request dropped before acknowledge");

    AST_CFG_SHARED_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_wr_req_o |-> (ref_clk_en_o && !por_rst_o)) // R6
        else $error("write requested while shared controls are down");

    AST_POR_UP_ALL_UTMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(por_rst_o) |-> (utmi_rst_o == '1)) // R7
        else $error("power-on reset asserted with a UTMI reset released");

    AST_REF_OFF_AFTER_POR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ref_clk_en_o) |-> $past(por_rst_o)) // R7
        else $error("reference clock dropped before power-on reset");

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port_chk
        AST_DONE_UTMI_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            port_done_o[g] |-> !utmi_rst_o[g]) // R12
            else $error("done while UTMI reset asserted");

        AST_UTMI_NEEDS_POR: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !utmi_rst_o[g] |-> !por_rst_o) // R2
            else $error("UTMI released under power-on reset");
    end

endmodule

// File: tb/tb_usbphy_bringup_seq.sv
module tb_usbphy_bringup_seq;

    localparam int NP   = 2;
    localparam int T_RF = 3;
    localparam int T_PO = 5;
    localparam int T_CF = 7;
    localparam int T_UT = 9;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          tick;
    logic [NP-1:0] init_req, exit_req;
    logic          ack;
    logic          ref_en, por_rst, cfg_req;
    logic [NP-1:0] utmi_rst, done;
    logic [2:0]    wr_port;
    logic [7:0]    wr_addr, wr_data;

    usbphy_bringup_seq #(
        .NUM_PORTS (NP), .REF_TICKS (T_RF), .POR_TICKS (T_PO),
        .CFG_TICKS (T_CF), .UTMI_TICKS (T_UT)
    ) dut (
        .clk_i (clk), .rst_ni (rst_n), .settle_tick_i (tick),
        .init_req_i (init_req), .exit_req_i (exit_req), .cfg_wr_ack_i (ack),
        .ref_clk_en_o (ref_en), .por_rst_o (por_rst), .utmi_rst_o (utmi_rst),
        .cfg_wr_req_o (cfg_req), .cfg_wr_port_o (wr_port),
        .cfg_wr_addr_o (wr_addr), .cfg_wr_data_o (wr_data), .port_done_o (done)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // settle tick: one pulse every 4 cycles, driven on the falling edge
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    // test-register writer model: acknowledges after two waiting cycles
    int wcnt = 0;
    int n_wr = 0;
    int bad_fields = 0;
    always @(negedge clk) begin
        if (ack) begin
            ack  = 1'b0;
            wcnt = 0;
        end else if (cfg_req) begin
            if (wcnt == 2) begin
                ack = 1'b1;
                n_wr++;
                if (wr_port != 3'd0 || wr_addr != 8'h06 || wr_data != 8'h04) bad_fields++;
            end else begin
                wcnt++;
            end
        end
    end

    // event monitor: stamps each output change and counts ticks in between
    int ev_no = 0, gap = 0;
    int st_ref_up, st_ref_dn, st_por_dn, st_por_up, st_cfg_up;
    int g_por_dn, g_cfg_up, n_ref_up = 0, n_ref_dn = 0, n_por_up = 0;
    int st_utmi_dn[NP], st_utmi_up[NP], st_done_up[NP];
    int g_utmi_dn[NP], g_done_up[NP];
    logic [6:0] prev;
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            prev = {ref_en, por_rst, cfg_req, utmi_rst, done};
            gap  = 0;
        end else if ({ref_en, por_rst, cfg_req, utmi_rst, done} != prev) begin
            ev_no++;
            if (ref_en && !prev[6])   begin st_ref_up = ev_no; n_ref_up++; end
            if (!ref_en && prev[6])   begin st_ref_dn = ev_no; n_ref_dn++; end
            if (!por_rst && prev[5])  begin st_por_dn = ev_no; g_por_dn = gap; end
            if (por_rst && !prev[5])  begin st_por_up = ev_no; n_por_up++; end
            if (cfg_req && !prev[4])  begin st_cfg_up = ev_no; g_cfg_up = gap; end
            for (int p = 0; p < NP; p++) begin
                if (!utmi_rst[p] && prev[2+p]) begin st_utmi_dn[p] = ev_no; g_utmi_dn[p] = gap; end
                if (utmi_rst[p] && !prev[2+p]) st_utmi_up[p] = ev_no;
                if (done[p] && !prev[p])       begin st_done_up[p] = ev_no; g_done_up[p] = gap; end
            end
            gap  = 0;
            prev = {ref_en, por_rst, cfg_req, utmi_rst, done};
        end else if (tick) begin
            gap++;
        end
    end

    // vector table: op 1=init 2=exit; mode 0=ignored 1=partial 2=full
    typedef struct packed {
        logic [1:0] op;
        logic       port;
        logic [1:0] mode;
        logic [1:0] done;
        logic       refen;
        logic       por;
        logic [1:0] utmi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b0, 2'd2, 2'b01, 1'b1, 1'b0, 2'b10},
        '{2'd1, 1'b1, 2'd1, 2'b11, 1'b1, 1'b0, 2'b00},
        '{2'd1, 1'b0, 2'd0, 2'b11, 1'b1, 1'b0, 2'b00},
        '{2'd2, 1'b0, 2'd1, 2'b10, 1'b1, 1'b0, 2'b01},
        '{2'd2, 1'b0, 2'd0, 2'b10, 1'b1, 1'b0, 2'b01},
        '{2'd2, 1'b1, 2'd2, 2'b00, 1'b0, 1'b1, 2'b11},
        '{2'd1, 1'b1, 2'd2, 2'b10, 1'b1, 1'b0, 2'b01},
        '{2'd2, 1'b1, 2'd2, 2'b00, 1'b0, 1'b1, 2'b11}
    };

    task automatic pulse(input logic [NP-1:0] ini, input logic [NP-1:0] ext);
        @(negedge clk);
        init_req = ini;
        exit_req = ext;
        @(negedge clk);
        init_req = '0;
        exit_req = '0;
    endtask

    task automatic check_outputs(input logic [1:0] d, input logic r, input logic p, input logic [1:0] u);
        chk("R5 done vector", int'(done), int'(d));
        chk("R8 ref_clk_en", int'(ref_en), int'(r));
        chk("R8 por_rst", int'(por_rst), int'(p));
        chk("R5 utmi_rst vector", int'(utmi_rst), int'(u));
        chk("R12 done implies utmi released", int'(done & utmi_rst), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ev0, ref0, wr0, refdn0, porup0;
        rst_n = 1'b0; init_req = '0; exit_req = '0; ack = 1'b0; tick = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 ref_clk_en", int'(ref_en), 0);
        chk("R1 por_rst", int'(por_rst), 1);
        chk("R1 utmi_rst", int'(utmi_rst), 3);
        chk("R1 done", int'(done), 0);
        chk("R1 cfg_req", int'(cfg_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            ev0 = ev_no; ref0 = n_ref_up; wr0 = n_wr; refdn0 = n_ref_dn; porup0 = n_por_up;
            if (VEC[v].op == 2'd1) pulse(2'b01 << VEC[v].port, 2'b00);
            else                   pulse(2'b00, 2'b01 << VEC[v].port);
            repeat (160) @(negedge clk);
            check_outputs(VEC[v].done, VEC[v].refen, VEC[v].por, VEC[v].utmi);
            if (VEC[v].mode == 2'd0) begin
                chk("R11 ignored request changes nothing", ev_no - ev0, 0);
            end else if (VEC[v].op == 2'd1) begin
                chk("R4 one write per bring-up", n_wr - wr0, 1);
                chk("R3 cfg settle ticks", g_utmi_dn[VEC[v].port], T_CF);
                chk("R3 utmi settle ticks", g_done_up[VEC[v].port], T_UT);
                chk("R2 utmi before done", int'(st_utmi_dn[VEC[v].port] < st_done_up[VEC[v].port]), 1);
                if (VEC[v].mode == 2'd2) begin
                    chk("R3 ref settle ticks", g_por_dn, T_RF);
                    chk("R3 por settle ticks", g_cfg_up, T_PO);
                    chk("R2 ref before por", int'(st_ref_up < st_por_dn), 1);
                    chk("R2 por before write", int'(st_por_dn < st_cfg_up), 1);
                    chk("R2 write before utmi", int'(st_cfg_up < st_utmi_dn[VEC[v].port]), 1);
                end else begin
                    chk("R6 shared controls untouched", n_ref_up - ref0, 0);
                end
            end else begin
                if (VEC[v].mode == 2'd2) begin
                    chk("R7 por follows utmi by one event", st_por_up - st_utmi_up[VEC[v].port], 1);
                    chk("R7 ref off follows por by one event", st_ref_dn - st_por_up, 1);
                end else begin
                    chk("R8 no shared shutdown", (n_ref_dn - refdn0) + (n_por_up - porup0), 0);
                end
            end
        end
        chk("R4 write fields port0 addr6 data4", bad_fields, 0);

        // R9: second init arrives while the first runs
        wr0 = n_wr; ref0 = n_ref_up;
        pulse(2'b01, 2'b00);
        repeat (3) @(negedge clk);
        pulse(2'b10, 2'b00);
        repeat (300) @(negedge clk);
        chk("R9 both ports done", int'(done), 3);
        chk("R9 port1 released after port0 done", int'(st_done_up[0] < st_utmi_dn[1]), 1);
        chk("R9 two writes", n_wr - wr0, 2);
        chk("R6 single clock enable", n_ref_up - ref0, 1);

        // R10: both exits in one cycle, port 0 first
        pulse(2'b00, 2'b11);
        repeat (40) @(negedge clk);
        chk("R10 port0 exit before port1", int'(st_utmi_up[0] < st_utmi_up[1]), 1);
        check_outputs(2'b00, 1'b0, 1'b1, 2'b11);

        // R10: exit of the only running port with init of the idle port
        pulse(2'b10, 2'b00);
        repeat (160) @(negedge clk);
        pulse(2'b01, 2'b10);
        repeat (200) @(negedge clk);
        chk("R10 shutdown before new bring-up", int'(st_ref_dn < st_ref_up), 1);
        check_outputs(2'b01, 1'b1, 1'b0, 2'b10);
        chk("R4 write fields after collisions", bad_fields, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule